// File: doc/BRIEF.md
# Single-Wire Frame Marker Tracker

This block sits behind a receiver for a padded single-wire serial link. The receiver has already turned line timing into a stream of link symbols: a lone pad bit, a short pulse, a sync pad, a complete data byte with its value, an idle indication and a low period. The tracker keeps a very short history of these symbols and finds the frame-level markers in it. It emits a one-cycle pulse for the start of a frame, for a wait-for-response marker and for the end of a frame. It also passes every data byte on with its position inside the current frame.

Frame boundaries are never taken from a length field or from a delimiter byte. They come only from symbol patterns. A run of sync pads opens a frame. Short pulses followed by a sync pad form a wait marker. The first byte after that marker is the response and closes the frame. An idle indication, a new frame start or a synchronisation error also closes a frame. The tracker does not judge frame content. Length, checksum and address checks belong to the layer above it.

Top module: `fmt_tracker`

## Requirements
- R1: When `SYNC_RUN` (default 3) sync pads arrive in a row, with no other accepted symbol between them, `frame_start` pulses for one cycle. The run is broken by a pad bit, a short pulse, a data byte, an idle indication or a rejected low period, and the count starts again from zero.
- R2: If a frame start is detected while a frame is open, `frame_end` pulses with `frame_err` low in the same cycle as `frame_start`, and the new frame is then open.
- R3: One or more short pulses followed by a sync pad produce exactly one `wait_mark` pulse. That sync pad does not count toward a frame-start run.
- R4: The first data byte after a wait marker is output with `byte_resp` high. If a frame is open, `frame_end` pulses with `frame_err` low in the same cycle as that byte. If no frame is open, `frame_end` stays low.
- R5: An idle indication closes an open frame: `frame_end` pulses with `frame_err` low. An idle indication with no frame open produces no pulse. In both cases the symbol history is cleared.
- R6: A low period is accepted when the last accepted symbol was a data byte, a short pulse or a wait marker. Any number of accepted low periods have no effect on the outputs or on the tracked state.
- R7: A low period in any other position is a synchronisation error. An open frame ends with `frame_end` and `frame_err` both high, and the sync-pad and short-pulse history is cleared.
- R8: Every data byte appears on `byte_valid`/`byte_data`. Its `byte_idx` is the count of bytes since the last frame start or frame end, starting at 0 and saturating at 2^`IDX_W`-1.
- R9: Symbol codes on `sym_kind` are: 0 pad bit, 1 short pulse, 2 sync pad, 3 data byte, 4 idle, 5 low period. Codes 6 and 7, and any cycle with `sym_valid` low, are ignored. All outputs are registered, respond one cycle after the symbol and are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_kind | input | 3 | Symbol code (see R9) |
| sym_data | input | 8 | Byte value for a data-byte symbol |
| frame_start | output | 1 | Frame-start marker pulse |
| wait_mark | output | 1 | Wait-for-response marker pulse |
| frame_end | output | 1 | Frame closed pulse |
| frame_err | output | 1 | With `frame_end`: the frame was closed by a synchronisation error |
| byte_valid | output | 1 | A data byte is presented |
| byte_data | output | 8 | Byte value |
| byte_idx | output | IDX_W | Frame-relative byte position |
| byte_resp | output | 1 | The byte is the response after a wait marker |

## Verification
The bench inserts every symbol code, including the two unused codes, between the second and third sync pads. This shows which symbols break a frame-start run, which ones are ignored, and that a short pulse turns the next sync pad into a wait marker. The bench also places every code in front of a low period inside an open frame. This separates accepted low periods from synchronisation errors, and error closes from idle closes. Directed sequences cover closing by response byte, by idle and by a new frame start, including the same closing events when no frame is open. A long frame carrying more than 256 bytes checks byte positions up to and past saturation, and checks that the index resets after a frame closes.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic [2:0] {
        SYM_PAD   = 3'd0,
        SYM_SHORT = 3'd1,
        SYM_SYNC  = 3'd2,
        SYM_BYTE  = 3'd3,
        SYM_IDLE  = 3'd4,
        SYM_LOW   = 3'd5
    } sym_kind_e;

    // One-hot view of the incoming symbol, all zero when nothing valid arrives
    typedef struct packed {
        logic pad;
        logic short_p;
        logic sync;
        logic data;
        logic idle;
        logic low;
    } sym_dec_t;

    // Marker events found by the pattern stage in the current cycle
    typedef struct packed {
        logic start;
        logic wait_m;
        logic resp;
    } marks_t;

    function automatic sym_dec_t decode_sym(input logic valid, input logic [2:0] kind);
        sym_dec_t d;
        d         = '0;
        d.pad     = valid && (kind == SYM_PAD);
        d.short_p = valid && (kind == SYM_SHORT);
        d.sync    = valid && (kind == SYM_SYNC);
        d.data    = valid && (kind == SYM_BYTE);
        d.idle    = valid && (kind == SYM_IDLE);
        d.low     = valid && (kind == SYM_LOW);
        return d;
    endfunction

endpackage

// File: rtl/fmt_low_guard.sv
module fmt_low_guard
    import fmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sym_dec_t dec,
    input  logic     wait_fire,
    output logic     sync_err
);

    // Set while the last accepted symbol allows a low period of any length
    logic accept_q;

    assign sync_err = dec.low && !accept_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_q <= 1'b0;
        end else if (dec.data || dec.short_p) begin
            accept_q <= 1'b1;
        end else if (dec.sync) begin
            accept_q <= wait_fire;
        end else if (dec.pad || dec.idle || sync_err) begin
            accept_q <= 1'b0;
        end
    end

    // R6
    low_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.low && !sync_err) |=> accept_q);

    // R7
    low_reject_chk: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> !accept_q);

endmodule

// File: rtl/fmt_pattern.sv
module fmt_pattern
    import fmt_pkg::*;
#(
    parameter int SYNC_RUN = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  sym_dec_t dec,
    input  logic     sync_err,
    output marks_t   marks
);

    localparam int CNT_W = $clog2(SYNC_RUN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SYNC_RUN - 1);

    logic [CNT_W-1:0] sync_cnt_q;
    logic             short_q;
    logic             armed_q;

    always_comb begin
        marks = '0;
        if (dec.sync) begin
            if (short_q) begin
                marks.wait_m = 1'b1;
            end else if (sync_cnt_q == LAST_CNT) begin
                marks.start = 1'b1;
            end
        end
        if (dec.data && armed_q) begin
            marks.resp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || dec.idle || sync_err) begin
            sync_cnt_q <= '0;
            short_q    <= 1'b0;
            armed_q    <= 1'b0;
        end else if (dec.short_p) begin
            sync_cnt_q <= '0;
            short_q    <= 1'b1;
        end else if (dec.sync) begin
            short_q <= 1'b0;
            if (short_q) begin
                sync_cnt_q <= '0;
                armed_q    <= 1'b1;
            end else if (sync_cnt_q == LAST_CNT) begin
                sync_cnt_q <= '0;
                armed_q    <= 1'b0;
            end else begin
                sync_cnt_q <= sync_cnt_q + 1'b1;
            end
        end else if (dec.data || dec.pad) begin
            sync_cnt_q <= '0;
            short_q    <= 1'b0;
            armed_q    <= 1'b0;
        end
    end

    // R1
    sync_run_chk: assert property (@(posedge clk) disable iff (rst)
        sync_cnt_q < CNT_W'(SYNC_RUN));

    // R3
    wait_arm_chk: assert property (@(posedge clk) disable iff (rst)
        marks.wait_m |=> armed_q);

endmodule

// File: rtl/fmt_frame_ctl.sv
module fmt_frame_ctl
    import fmt_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sym_dec_t          dec,
    input  logic [DATA_W-1:0] sym_data,
    input  marks_t            marks,
    input  logic              sync_err,
    output logic              frame_start_o,
    output logic              wait_mark_o,
    output logic              frame_end_o,
    output logic              frame_err_o,
    output logic              byte_valid_o,
    output logic [DATA_W-1:0] byte_data_o,
    output logic [IDX_W-1:0]  byte_idx_o,
    output logic              byte_resp_o
);

    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             in_frame_q;
    logic [IDX_W-1:0] idx_q;
    logic             close_any;

    assign close_any = in_frame_q && (marks.start || marks.resp || dec.idle || sync_err);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q    <= 1'b0;
            idx_q         <= '0;
            frame_start_o <= 1'b0;
            wait_mark_o   <= 1'b0;
            frame_end_o   <= 1'b0;
            frame_err_o   <= 1'b0;
            byte_valid_o  <= 1'b0;
            byte_data_o   <= '0;
            byte_idx_o    <= '0;
            byte_resp_o   <= 1'b0;
        end else begin
            frame_start_o <= marks.start;
            wait_mark_o   <= marks.wait_m;
            frame_end_o   <= close_any;
            frame_err_o   <= in_frame_q && sync_err;
            byte_valid_o  <= dec.data;
            byte_resp_o   <= marks.resp;
            if (dec.data) begin
                byte_data_o <= sym_data;
                byte_idx_o  <= idx_q;
            end
            if (marks.start || close_any) begin
                idx_q <= '0;
            end else if (dec.data && idx_q != IDX_MAX) begin
                idx_q <= idx_q + 1'b1;
            end
            if (marks.start) begin
                in_frame_q <= 1'b1;
            end else if (close_any) begin
                in_frame_q <= 1'b0;
            end
        end
    end

    // R7
    err_with_end_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> frame_end_o);

    // R2
    end_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end_o |-> $past(in_frame_q));

    // R4
    resp_is_byte_chk: assert property (@(posedge clk) disable iff (rst)
        byte_resp_o |-> byte_valid_o);

    // R9
    one_event_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_start_o, wait_mark_o, byte_valid_o}));

endmodule

// File: rtl/fmt_tracker.sv
module fmt_tracker
    import fmt_pkg::*;
#(
    parameter int SYNC_RUN = 3,
    parameter int IDX_W    = 8,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  logic [2:0]        sym_kind,
    input  logic [DATA_W-1:0] sym_data,
    output logic              frame_start,
    output logic              wait_mark,
    output logic              frame_end,
    output logic              frame_err,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic [IDX_W-1:0]  byte_idx,
    output logic              byte_resp
);

    sym_dec_t dec;
    marks_t   marks;
    logic     sync_err;

    assign dec = decode_sym(sym_valid, sym_kind);

    fmt_low_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .wait_fire (marks.wait_m),
        .sync_err  (sync_err)
    );

    fmt_pattern #(.SYNC_RUN(SYNC_RUN)) u_pattern (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .sync_err (sync_err),
        .marks    (marks)
    );

    fmt_frame_ctl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_frame (
        .clk           (clk),
        .rst           (rst),
        .dec           (dec),
        .sym_data      (sym_data),
        .marks         (marks),
        .sync_err      (sync_err),
        .frame_start_o (frame_start),
        .wait_mark_o   (wait_mark),
        .frame_end_o   (frame_end),
        .frame_err_o   (frame_err),
        .byte_valid_o  (byte_valid),
        .byte_data_o   (byte_data),
        .byte_idx_o    (byte_idx),
        .byte_resp_o   (byte_resp)
    );

endmodule

// File: tb/fmt_tracker_tb_top.sv
module fmt_tracker_tb_top;

    localparam int IDX_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sym_valid = 1'b0;
    logic [2:0]       sym_kind = '0;
    logic [7:0]       sym_data = '0;
    logic             frame_start, wait_mark, frame_end, frame_err;
    logic             byte_valid, byte_resp;
    logic [7:0]       byte_data;
    logic [IDX_W-1:0] byte_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [5:0] flags;

    always #4 clk = ~clk;

    fmt_tracker #(.SYNC_RUN(3), .IDX_W(IDX_W), .DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_kind(sym_kind),
        .sym_data(sym_data), .frame_start(frame_start), .wait_mark(wait_mark),
        .frame_end(frame_end), .frame_err(frame_err), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_idx(byte_idx), .byte_resp(byte_resp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flags = {frame_start, wait_mark, frame_end, frame_err, byte_valid, byte_resp}
    task automatic sym(input logic [2:0] k, input logic [7:0] d, input logic v = 1'b1);
        @(negedge clk);
        sym_valid = v;
        sym_kind  = k;
        sym_data  = d;
        @(posedge clk);
        #1;
        sym_valid = 1'b0;
        flags = {frame_start, wait_mark, frame_end, frame_err, byte_valid, byte_resp};
    endtask

    task automatic symf(input logic [2:0] k, input logic [7:0] d, input logic [5:0] exp,
                        input string req);
        sym(k, d);
        chk(flags == exp, req, int'(flags), int'(exp));
    endtask

    task automatic open_frame(input string req);
        symf(3'd2, 8'h00, 6'b000000, req);
        symf(3'd2, 8'h00, 6'b000000, req);
        sym(3'd2, 8'h00);
        chk(flags[5] == 1'b1, req, int'(flags), 32'h20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk({frame_start, wait_mark, frame_end, frame_err, byte_valid, byte_resp} == 6'b0
            && byte_idx == 0 && byte_data == 0, "R9 reset",
            int'({frame_start, wait_mark, frame_end, frame_err, byte_valid, byte_resp}), 0);

        // R1 basic frame start
        symf(3'd2, 8'h00, 6'b000000, "R1 sync1");
        symf(3'd2, 8'h00, 6'b000000, "R1 sync2");
        symf(3'd2, 8'h00, 6'b100000, "R1 sync3");
        // R8 bytes with index
        symf(3'd3, 8'h11, 6'b000010, "R8 byte0");
        chk(byte_idx == 0 && byte_data == 8'h11, "R8 idx0", int'(byte_idx), 0);
        symf(3'd3, 8'h22, 6'b000010, "R8 byte1");
        chk(byte_idx == 1 && byte_data == 8'h22, "R8 idx1", int'(byte_idx), 1);
        // R3 shorts then sync form one wait marker
        symf(3'd1, 8'h00, 6'b000000, "R3 short");
        symf(3'd1, 8'h00, 6'b000000, "R3 short");
        symf(3'd2, 8'h00, 6'b010000, "R3 wait");
        // R6 low after wait accepted
        symf(3'd5, 8'h00, 6'b000000, "R6 low after wait");
        symf(3'd5, 8'h00, 6'b000000, "R6 low after wait");
        // R4 response closes frame
        symf(3'd3, 8'h77, 6'b001011, "R4 response");
        chk(byte_idx == 2, "R4 resp idx", int'(byte_idx), 2);
        // R8 index reset after close
        symf(3'd3, 8'h33, 6'b000010, "R8 idx after close");
        chk(byte_idx == 0, "R8 idx after close", int'(byte_idx), 0);
        // R4 response with no frame open
        symf(3'd1, 8'h00, 6'b000000, "R4 short");
        symf(3'd2, 8'h00, 6'b010000, "R4 wait");
        symf(3'd3, 8'h44, 6'b000011, "R4 resp no frame");

        // R5 idle
        symf(3'd4, 8'h00, 6'b000000, "R5 idle no frame");
        open_frame("R5 open");
        symf(3'd3, 8'h01, 6'b000010, "R5 byte");
        symf(3'd4, 8'h00, 6'b001000, "R5 idle closes");
        symf(3'd4, 8'h00, 6'b000000, "R5 idle again");
        // R5 idle clears history
        symf(3'd2, 8'h00, 6'b000000, "R5 s");
        symf(3'd2, 8'h00, 6'b000000, "R5 s");
        symf(3'd4, 8'h00, 6'b000000, "R5 idle mid");
        symf(3'd2, 8'h00, 6'b000000, "R5 s after idle");

        // R2 restart while open
        symf(3'd4, 8'h00, 6'b000000, "R2 clean");
        open_frame("R2 open");
        symf(3'd3, 8'h05, 6'b000010, "R2 byte");
        symf(3'd2, 8'h00, 6'b000000, "R2 s");
        symf(3'd2, 8'h00, 6'b000000, "R2 s");
        symf(3'd2, 8'h00, 6'b101000, "R2 restart");
        symf(3'd3, 8'h06, 6'b000010, "R2 new frame byte");
        chk(byte_idx == 0, "R2 idx", int'(byte_idx), 0);

        // R7 sync error
        symf(3'd2, 8'h00, 6'b000000, "R7 s");
        symf(3'd2, 8'h00, 6'b000000, "R7 s");
        symf(3'd5, 8'h00, 6'b001100, "R7 low error");
        symf(3'd2, 8'h00, 6'b000000, "R7 history cleared");
        symf(3'd2, 8'h00, 6'b000000, "R7 s");
        symf(3'd2, 8'h00, 6'b100000, "R7 new start, no end");

        // R6 lows after byte
        symf(3'd3, 8'h09, 6'b000010, "R6 byte");
        symf(3'd5, 8'h00, 6'b000000, "R6 low");
        symf(3'd5, 8'h00, 6'b000000, "R6 low");
        symf(3'd4, 8'h00, 6'b001000, "R6 still open");

        // R9 ignored codes and invalid cycles
        symf(3'd2, 8'h00, 6'b000000, "R9 s");
        symf(3'd2, 8'h00, 6'b000000, "R9 s");
        symf(3'd6, 8'h00, 6'b000000, "R9 code6");
        symf(3'd7, 8'h00, 6'b000000, "R9 code7");
        sym(3'd2, 8'h00, 1'b0);
        chk(flags == 6'b0, "R9 invalid", int'(flags), 0);
        symf(3'd2, 8'h00, 6'b100000, "R9 start");

        // R1 sweep: each code between second and third sync pad
        for (int k = 0; k < 8; k++) begin
            logic [5:0] e;
            sym(3'd4, 8'h00);
            symf(3'd2, 8'h00, 6'b000000, "R1 sweep s1");
            symf(3'd2, 8'h00, 6'b000000, "R1 sweep s2");
            sym(3'(k), 8'h00);
            e = (k >= 6) ? 6'b100000 : (k == 1) ? 6'b010000 : 6'b000000;
            symf(3'd2, 8'h00, e, "R1 sweep s3");
        end

        // R7 sweep: each code before a low period inside an open frame
        for (int k = 0; k < 8; k++) begin
            bit open_after, accepted;
            logic [5:0] e;
            sym(3'd4, 8'h00);
            open_frame("R7 sweep open");
            sym(3'(k), 8'hA5);
            open_after = !(k == 4 || k == 5);
            accepted   = (k == 1 || k == 3);
            e = (open_after && !accepted) ? 6'b001100 : 6'b000000;
            symf(3'd5, 8'h00, e, "R7 sweep low");
        end

        // R8 long frame with saturation
        sym(3'd4, 8'h00);
        open_frame("R8 long open");
        for (int i = 0; i < 260; i++) begin
            int ei;
            sym(3'd3, 8'(i) ^ 8'h5A);
            ei = (i > 255) ? 255 : i;
            chk(byte_valid && byte_idx == IDX_W'(ei) && byte_data == (8'(i) ^ 8'h5A),
                "R8 long idx", int'(byte_idx), ei);
        end
        symf(3'd4, 8'h00, 6'b001000, "R8 long close");
        symf(3'd3, 8'h10, 6'b000010, "R8 idx reset");
        chk(byte_idx == 0, "R8 idx reset", int'(byte_idx), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule